// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a 32-bit integer pipeline and a word-wide, byte-addressed data memory. Each request carries a base register value, a signed 16-bit byte offset, an access width (byte, halfword or word), a signedness bit and a load/store direction. In the cycle the request is accepted, the block forms the effective address and checks that the access is aligned to its own width. It then drives the memory strobe, a word-aligned address, per-lane write enables and lane-replicated store data. The memory bus is big-endian: the byte at word offset 0 is the most significant byte of the word, so write-enable bit 3 and data bits 31:24 serve offset 0.

For a load, the memory returns its word one cycle after acceptance. The block keeps the width, signedness and low address bits of that request in a register. It picks out the addressed byte or halfword and widens it to 32 bits with sign or zero extension, so every load result fills the whole destination register. A misaligned access reaches no memory lane and raises a one-cycle error pulse in the response cycle.

The request side uses a valid/ready handshake. `req_ready` follows the memory grant `mem_gnt` combinationally, and a request is taken in any cycle where both `req_valid` and `req_ready` are high. The requester must hold the request stable while `req_ready` is low. The response side has no back-pressure. `rsp_valid` is a single-cycle qualifier that the pipeline's writeback stage must take when it is raised. A new request may be accepted in the same cycle that the previous load's response is presented.

Top module: `ldst_lane_unit`

## Requirements
- R1: The effective address is `req_base` plus the sign-extended `req_offset`, modulo 2^32. For an accepted aligned access, `mem_addr` is this address with bits 1:0 forced to 0.
- R2: Width encoding on `req_size` is 0 = byte, 1 = halfword, 2 = word; code 3 is illegal. A halfword with effective address bit 0 set, a word with either of address bits 1:0 set, or code 3 is misaligned. A misaligned access drives `mem_en` and `mem_we` low, and `rsp_err` is high for exactly the one cycle after acceptance.
- R3: An aligned word store drives `mem_we` = 1111 and `mem_wdata` = `req_wsrc`.
- R4: An aligned halfword store places `req_wsrc[15:0]` in both halves of `mem_wdata`. It drives `mem_we` = 1100 when address bit 1 is 0 and 0011 when it is 1.
- R5: A byte store places `req_wsrc[7:0]` in all four lanes. It drives a single `mem_we` bit, bit (3 - address[1:0]).
- R6: An accepted aligned load drives `mem_en` = 1 and `mem_we` = 0000. Exactly one cycle later `rsp_valid` is 1, and `rsp_data` is formed from `mem_rdata` in that cycle using the width, signedness and address of that same request, even when a new request is accepted in that cycle.
- R7: A byte load takes `mem_rdata` bits [31-8a : 24-8a] for address offset a. A signed byte load sign-extends this byte to 32 bits; an unsigned byte load fills bits 31:8 with 0.
- R8: A halfword load takes `mem_rdata[31:16]` when address bit 1 is 0 and `mem_rdata[15:0]` when it is 1. It sign-extends or zero-extends according to `req_signed`.
- R9: A word load returns `mem_rdata` unchanged, whatever `req_signed` is.
- R10: `req_ready` equals `mem_gnt`. Without acceptance, `mem_en` and `mem_we` stay 0, and neither `rsp_valid` nor `rsp_err` rises in the next cycle.
- R11: During and right after reset, `rsp_valid` and `rsp_err` are 0.
- R12: A misaligned load still gets a response, with `rsp_valid` = 1, `rsp_data` = 0 and `rsp_err` = 1, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code |
| req_signed | input | 1 | Sign-extend narrow load result |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed byte offset |
| req_wsrc | input | 32 | Store source register |
| mem_gnt | input | 1 | Memory can take an access this cycle |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 4 | Per-lane write enables, bit 3 = offset 0 |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Load word, valid one cycle after acceptance |
| rsp_valid | output | 1 | Load result present |
| rsp_data | output | 32 | Extended load result |
| rsp_err | output | 1 | Misalignment pulse |

## Verification
The two functions that share a cycle are the response stage of one load and the request stage of the next access. In the cycle a load result is formatted, another request, often with a different width, lane or direction, is being decoded and driven onto the memory bus. The bench provokes this with unbroken runs of back-to-back random requests, with directed pairs where a signed byte load is followed at once by a word store or a misaligned halfword, and with grant gaps in between. It judges each response against a reference computed from the attributes of the earlier request and the word returned in that cycle. In the same cycle it checks the strobes, enables and data of the new request against its own reference.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input  logic [XLEN-1:0]  base,
  input  logic [OFF_W-1:0] offset,
  input  acc_size_e        size,
  output logic [XLEN-1:0]  ea,
  output logic             misalign
);
  localparam int NB = XLEN / 8;
  localparam int LW = $clog2(NB);

  // carry out of the top bit is dropped by the width of ea
  assign ea = base + {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};

  always_comb begin
    unique case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = ea[0];
      SZ_WORD: misalign = |ea[LW-1:0];
      default: misalign = 1'b1;
    endcase
  end
endmodule

// File: rtl/ldst_store_lane.sv
module ldst_store_lane
  import ldst_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                  active,
  input  acc_size_e             size,
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  logic [XLEN-1:0]       src,
  output logic [XLEN/8-1:0]     we,
  output logic [XLEN-1:0]       wdata
);
  localparam int NB = XLEN / 8;
  localparam int LW = $clog2(NB);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    // lane i carries byte offset NB-1-i (big-endian)
    localparam logic [LW-1:0] BYTE_OFS = LW'(NB - 1 - i);
    localparam logic [LW-1:0] HALF_OFS = LW'((NB - 1 - i) & ~1);

    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          wdata[8*i +: 8] = src[7:0];
          we[i]           = active && (lane == BYTE_OFS);
        end
        SZ_HALF: begin
          wdata[8*i +: 8] = src[8*(i%2) +: 8];
          we[i]           = active && ({lane[LW-1:1], 1'b0} == HALF_OFS);
        end
        SZ_WORD: begin
          wdata[8*i +: 8] = src[8*i +: 8];
          we[i]           = active;
        end
        default: begin
          wdata[8*i +: 8] = src[8*i +: 8];
          we[i]           = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ldst_load_fmt.sv
module ldst_load_fmt
  import ldst_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  acc_size_e                 size,
  input  logic                      sgn,
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  logic                      kill,
  input  logic [XLEN-1:0]           word,
  output logic [XLEN-1:0]           data
);
  localparam int NB = XLEN / 8;
  localparam int LW = $clog2(NB);

  logic [LW-1:0]   byte_shift_idx;
  logic [LW-1:0]   half_shift_idx;
  logic [XLEN-1:0] byte_aligned;
  logic [XLEN-1:0] half_aligned;
  logic [7:0]      sel_byte;
  logic [15:0]     sel_half;

  assign byte_shift_idx = LW'(NB - 1) - lane;
  assign half_shift_idx = LW'(NB - 2) - {lane[LW-1:1], 1'b0};
  assign byte_aligned   = word >> (8 * byte_shift_idx);
  assign half_aligned   = word >> (8 * half_shift_idx);
  assign sel_byte       = byte_aligned[7:0];
  assign sel_half       = half_aligned[15:0];

  always_comb begin
    if (kill) begin
      data = '0;
    end else begin
      unique case (size)
        SZ_BYTE: data = {{(XLEN-8){sgn & sel_byte[7]}}, sel_byte};
        SZ_HALF: data = {{(XLEN-16){sgn & sel_half[15]}}, sel_half};
        default: data = word;
      endcase
    end
  end
endmodule

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit
  import ldst_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [XLEN-1:0]   req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [XLEN-1:0]   req_wsrc,
  input  logic              mem_gnt,
  output logic              mem_en,
  output logic [XLEN/8-1:0] mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   rsp_data,
  output logic              rsp_err
);
  localparam int NB = XLEN / 8;
  localparam int LW = $clog2(NB);

  acc_size_e       cur_size;
  logic [XLEN-1:0] ea;
  logic            misalign;
  logic            accept;

  acc_size_e       pend_size;
  logic            pend_sgn;
  logic [LW-1:0]   pend_lane;
  logic            pend_load;
  logic            pend_err;

  assign cur_size  = acc_size_e'(req_size);
  assign req_ready = mem_gnt;
  assign accept    = req_valid && req_ready;

  ldst_addr_gen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_addr (
    .base     (req_base),
    .offset   (req_offset),
    .size     (cur_size),
    .ea       (ea),
    .misalign (misalign)
  );

  ldst_store_lane #(.XLEN(XLEN)) u_store (
    .active (accept && req_store && !misalign),
    .size   (cur_size),
    .lane   (ea[LW-1:0]),
    .src    (req_wsrc),
    .we     (mem_we),
    .wdata  (mem_wdata)
  );

  assign mem_en   = accept && !misalign;
  assign mem_addr = {ea[XLEN-1:LW], {LW{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_load <= 1'b0;
      pend_err  <= 1'b0;
      pend_size <= SZ_WORD;
      pend_sgn  <= 1'b0;
      pend_lane <= '0;
    end else begin
      pend_load <= accept && !req_store;
      pend_err  <= accept && misalign;
      if (accept) begin
        pend_size <= cur_size;
        pend_sgn  <= req_signed;
        pend_lane <= ea[LW-1:0];
      end
    end
  end

  ldst_load_fmt #(.XLEN(XLEN)) u_fmt (
    .size (pend_size),
    .sgn  (pend_sgn),
    .lane (pend_lane),
    .kill (pend_err),
    .word (mem_rdata),
    .data (rsp_data)
  );

  assign rsp_valid = pend_load;
  assign rsp_err   = pend_err;

  // write lanes only for an accepted store
  assert_we_needs_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> (req_valid && req_ready && req_store));
  // enables never coexist with the misalignment detector
  assert_no_we_misalign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> !misalign);
  // error pulse traces back to an accepted request
  assert_err_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(req_valid && req_ready));
  // response one cycle after an accepted load
  assert_rsp_follows_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_store));
  assert_byte_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mem_we) && cur_size == SZ_BYTE) |-> ($countones(mem_we) == 1));
  assert_half_we_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mem_we) && cur_size == SZ_HALF) |-> ($countones(mem_we) == 2));
  assert_word_we_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mem_we) && cur_size == SZ_WORD) |-> (&mem_we));
  assert_byte_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && pend_size == SZ_BYTE && !pend_sgn) |-> (rsp_data[XLEN-1:8] == '0));
  assert_misload_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));
endmodule

// File: tb/ldst_lane_unit_tb_top.sv
`timescale 1ns/1ps
module ldst_lane_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_signed = 1'b0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wsrc = '0;
  logic        mem_gnt = 1'b0;
  logic        mem_en;
  logic [3:0]  mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_err;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expectation carried from one request to its response cycle
  bit         p_load = 1'b0;
  bit         p_err = 1'b0;
  logic [1:0] p_sz = 2'b00;
  bit         p_sg = 1'b0;
  logic [1:0] p_a = 2'b00;

  always #4 clk = ~clk;

  ldst_lane_unit dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_store, .req_size, .req_signed,
    .req_base, .req_offset, .req_wsrc, .mem_gnt, .mem_en, .mem_we, .mem_addr,
    .mem_wdata, .mem_rdata, .rsp_valid, .rsp_data, .rsp_err
  );

  function automatic logic [31:0] f_ea(logic [31:0] b, logic [15:0] o);
    return b + {{16{o[15]}}, o};
  endfunction

  function automatic bit f_mis(logic [1:0] sz, logic [1:0] a);
    case (sz)
      2'd0: return 1'b0;
      2'd1: return a[0];
      2'd2: return a != 2'd0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [3:0] f_we(logic [1:0] sz, logic [1:0] a);
    case (sz)
      2'd0: return 4'b1000 >> a;
      2'd1: return a[1] ? 4'b0011 : 4'b1100;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] f_wd(logic [1:0] sz, logic [31:0] s);
    case (sz)
      2'd0: return {4{s[7:0]}};
      2'd1: return {2{s[15:0]}};
      default: return s;
    endcase
  endfunction

  function automatic logic [31:0] f_ld(logic [1:0] sz, bit sg, logic [1:0] a, logic [31:0] w);
    logic [31:0] sh;
    logic [15:0] h;
    case (sz)
      2'd0: begin
        sh = w >> (8 * (3 - int'(a)));
        return sg ? {{24{sh[7]}}, sh[7:0]} : {24'h0, sh[7:0]};
      end
      2'd1: begin
        h = a[1] ? w[15:0] : w[31:16];
        return sg ? {{16{h[15]}}, h} : {16'h0, h};
      end
      default: return w;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one cycle: drive a request and the memory word answering the previous one
  task automatic step(bit v, bit st, logic [1:0] sz, bit sg, logic [31:0] b,
                      logic [15:0] o, logic [31:0] s, bit g, logic [31:0] rd);
    logic [31:0] ea;
    logic [31:0] exp_d;
    bit acc, mis;
    string tg;
    @(negedge clk);
    mem_rdata = rd;
    req_valid = v; req_store = st; req_size = sz; req_signed = sg;
    req_base = b; req_offset = o; req_wsrc = s; mem_gnt = g;
    #1;
    // response of the earlier request (R6, R7, R8, R9, R12, R10)
    if (p_load) begin
      chk(rsp_valid == 1'b1, "R6 rsp_valid", 32'(rsp_valid), 32'd1);
      exp_d = p_err ? 32'h0 : f_ld(p_sz, p_sg, p_a, rd);
      tg = p_err ? "R12 misaligned load data" :
           (p_sz == 2'd0) ? "R7 byte load" : (p_sz == 2'd1) ? "R8 half load" : "R9 word load";
      chk(rsp_data == exp_d, tg, rsp_data, exp_d);
    end else begin
      chk(rsp_valid == 1'b0, "R10 no response", 32'(rsp_valid), 32'd0);
    end
    chk(rsp_err == p_err, "R2 error pulse", 32'(rsp_err), 32'(p_err));
    // request side
    acc = v && g;
    ea  = f_ea(b, o);
    mis = f_mis(sz, ea[1:0]);
    chk(req_ready == g, "R10 ready follows grant", 32'(req_ready), 32'(g));
    chk(mem_en == (acc && !mis), "R2 R6 R10 mem_en", 32'(mem_en), 32'(acc && !mis));
    chk(mem_we == ((acc && st && !mis) ? f_we(sz, ea[1:0]) : 4'b0000),
        "R2 R6 R10 write enables", 32'(mem_we),
        32'((acc && st && !mis) ? f_we(sz, ea[1:0]) : 4'b0000));
    if (acc && !mis) begin
      chk(mem_addr == {ea[31:2], 2'b00}, "R1 address", mem_addr, {ea[31:2], 2'b00});
      if (st) begin
        tg = (sz == 2'd0) ? "R5 byte store data" : (sz == 2'd1) ? "R4 half store data" : "R3 word store data";
        chk(mem_wdata == f_wd(sz, s), tg, mem_wdata, f_wd(sz, s));
      end
    end
    p_load = acc && !st;
    p_err  = acc && mis;
    if (acc) begin
      p_sz = sz; p_sg = sg; p_a = ea[1:0];
    end
  endtask

  task automatic idle(logic [31:0] rd);
    step(1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 16'h0, 32'h0, 1'b1, rd);
  endtask

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(rsp_err == 1'b0, "R11 reset rsp_err", 32'(rsp_err), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rsp_valid == 1'b0 && rsp_err == 1'b0, "R11 after reset", 32'({rsp_valid, rsp_err}), 32'd0);

    // R3 word store; R1 negative offset
    step(1, 1, 2'd2, 0, 32'h0000_1010, 16'hFFF4, 32'hCAFE_F00D, 1, 32'h0);
    // R4 halfword stores at both halves
    step(1, 1, 2'd1, 0, 32'h0000_2000, 16'h0000, 32'h1234_ABCD, 1, 32'h0);
    step(1, 1, 2'd1, 0, 32'h0000_2000, 16'h0002, 32'h1234_ABCD, 1, 32'h0);
    // R5 byte store at every offset
    for (int a = 0; a < 4; a++)
      step(1, 1, 2'd0, 0, 32'h0000_3000, 16'(a), 32'h5555_AA7E, 1, 32'h0);
    // R7 signed and unsigned byte loads across all lanes, back to back
    for (int a = 0; a < 4; a++) begin
      step(1, 0, 2'd0, 1, 32'h0000_4000, 16'(a), 32'h0, 1, 32'h0);
      step(1, 0, 2'd0, 0, 32'h0000_4000, 16'(a), 32'h0, 1, 32'h80F1_7F82);
    end
    // R8 half loads, signed followed by unsigned
    step(1, 0, 2'd1, 1, 32'h0000_5000, 16'h0002, 32'h0, 1, 32'h80F1_7F82);
    step(1, 0, 2'd1, 0, 32'h0000_5000, 16'h0000, 32'h0, 1, 32'h1234_8001);
    // R9 word load with signed set; R6 next cycle is a word store
    step(1, 0, 2'd2, 1, 32'h0000_5000, 16'h0004, 32'h0, 1, 32'h8000_0000);
    step(1, 1, 2'd2, 0, 32'h0000_6000, 16'h0000, 32'h0BAD_BEEF, 1, 32'h8765_4321);
    // R2 misaligned: half at odd, word at 2, illegal code; R12 misaligned load
    step(1, 1, 2'd1, 0, 32'h0000_7001, 16'h0000, 32'hFFFF_FFFF, 1, 32'h0);
    step(1, 0, 2'd2, 1, 32'h0000_7000, 16'h0002, 32'h0, 1, 32'h0);
    step(1, 1, 2'd3, 0, 32'h0000_7000, 16'h0000, 32'h1, 1, 32'hDEAD_BEEF);
    step(1, 0, 2'd1, 1, 32'h0000_7003, 16'h0000, 32'h0, 1, 32'h0);
    // R1 wrap past the top of the address space
    step(1, 0, 2'd0, 1, 32'hFFFF_FFFE, 16'h0004, 32'h0, 1, 32'hFFFF_FFFF);
    // R10 valid without grant, then grant without valid
    step(1, 1, 2'd2, 0, 32'h0000_8000, 16'h0000, 32'h1111_1111, 0, 32'hA5A5_A5A5);
    step(0, 0, 2'd0, 0, 32'h0000_8000, 16'h0000, 32'h0, 1, 32'h5A5A_5A5A);
    idle(32'h0);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] sz;
      logic [15:0] off;
      sz  = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      off = ($urandom % 2 == 0) ? 16'($urandom % 64) : 16'($urandom);
      step(($urandom % 8) != 0, $urandom % 2, sz, $urandom % 2, $urandom, off,
           $urandom, ($urandom % 6) != 0, $urandom);
    end
    idle($urandom);
    idle($urandom);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule